// File: doc/BRIEF.md
# Pixel Row Command Sequencer

This block generates the digital control lines for a pixel matrix whose pixels hold several analog frames in in-pixel memory cells. An external pattern generator feeds six control inputs (a line-step flag, a serial select data bit, precharge, read, power-on and write) that repeat a fixed six-cycle pattern. The block registers these inputs on the single main clock. It divides that clock by six to obtain a one-cycle row-step enable. From the registered inputs it forms an 8-bit command word per row slot.

Two command words are built side by side. The first drives the sample-and-hold rows that have four storage cells per pixel. The data bit is steered onto one of four capacitor-select lines by a pointer that moves on each line-step flag. The second drives the clamping-capacitor rows. Their select pointer moves only once every full pass of the row chain (48 steps, 288 cycles). The last of its four positions drives no select. On each step enable the words enter a 48-stage row chain: 40 stages for the sample-and-hold rows and 8 for the clamping rows. Each row sees a word only when the word has walked down to it.

Top module: `pix_row_seq`

## Requirements
- R1: While `rst` is high at a rising edge, every stage of the row chain, both select pointers, the row-step counter and the input registers clear. After that edge `row_cmd_o` is all zero and `step_o` is low.
- R2: Each control input is registered once on the rising edge. A command word loaded at a step edge therefore reflects the inputs driven before the previous edge, not those present at the step edge itself.
- R3: `step_o` is high for exactly one cycle in every six. After reset is released it first goes high during the sixth cycle, which is after five rising edges.
- R4: In every row word, at most one of the four select bits is high.
- R5: The sample-and-hold select pointer starts at 0 and moves to the next position (3 wraps to 0) at each edge where the registered line-step flag is high. The registered data bit is copied onto select bit `4+pointer` of the word, and all other select bits are zero.
- R6: Word layout: bits 7:4 are the select lines (bit 4 is capacitor 0), bit 3 is write, bit 2 is power-on, bit 1 is read and bit 0 is precharge. The four control bits are the registered inputs.
- R7: At an edge where `step_o` is high, row 0 loads the sample-and-hold word and rows 1 to 39 each take the word of the row above. Row 40 loads the clamping word and rows 41 to 47 shift in the same way. Row `i` occupies bits `8*i+7 : 8*i` of `row_cmd_o`.
- R8: At an edge where `step_o` is low, `row_cmd_o` keeps its value.
- R9: The clamping select phase starts at 0 and advances by one (3 wraps to 0) after every 48 step edges, which is every 288 cycles. Phases 0 to 2 copy the registered data bit onto select bit `4+phase` of the clamping word.
- R10: In clamping phase 3, the select bits of the clamping word are all zero, whatever the data input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| line_step_i | input | 1 | Advance the sample-and-hold capacitor pointer |
| data_i | input | 1 | Serial select bit routed to the active capacitor |
| prech_i | input | 1 | Precharge request |
| read_i | input | 1 | Read request |
| pwr_i | input | 1 | Amplifier power-on request |
| write_i | input | 1 | Write request |
| step_o | output | 1 | One-cycle row-step enable |
| row_cmd_o | output | 384 | Command words of rows 0..47, 8 bits per row |

## Verification
An input change is registered at the next rising edge. It reaches row 0 or row 40 at the first later edge where `step_o` is high, and it reaches row `i` after `i` further step edges. `step_o` itself is due in the sixth cycle after reset and every sixth cycle after that. The clamping phase moves 288 cycles apart. The bench keeps a cycle-level expectation that advances on the same rising edges as the design and drives inputs on falling edges. It compares every output on the falling edge, so every register delay is already counted when a result is read. A pseudo-random input stream and a mid-run reset cover pointer wrap, every clamping phase including the blank one, and the hold between steps.

// File: rtl/pix_seq_pkg.sv
package pix_seq_pkg;

    localparam int ROWS       = 48;
    localparam int STD_ROWS   = 40;
    localparam int CLAMP_ROWS = ROWS - STD_ROWS;
    localparam int DIV        = 6;
    localparam int NCAP       = 4;
    localparam int PTR_W      = $clog2(NCAP);
    localparam int CNT_W      = $clog2(DIV);
    localparam int ROWC_W     = $clog2(ROWS);
    localparam int CMD_W      = NCAP + 4;

    typedef struct packed {
        logic [NCAP-1:0] sel;
        logic            write;
        logic            pwr;
        logic            read;
        logic            prech;
    } cmd_t;

    typedef struct packed {
        logic line;
        logic data;
        logic prech;
        logic read;
        logic pwr;
        logic write;
    } ctl_t;

    function automatic logic [NCAP-1:0] route_sel(input logic [PTR_W-1:0] p,
                                                  input logic d);
        logic [NCAP-1:0] v;
        v    = '0;
        v[p] = d;
        return v;
    endfunction

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(NCAP-1)) ? '0 : p + PTR_W'(1);
    endfunction

endpackage

// File: rtl/pix_sample.sv
module pix_sample
    import pix_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t d_i,
    output ctl_t q_o
);
    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= d_i;
    end
endmodule

// File: rtl/pix_step_div.sv
module pix_step_div
    import pix_seq_pkg::*;
#(
    parameter int RATIO = DIV
) (
    input  logic clk,
    input  logic rst,
    output logic step_o
);
    localparam int W = (RATIO > 1) ? $clog2(RATIO) : 1;
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                         cnt <= '0;
        else if (cnt == W'(RATIO-1))     cnt <= '0;
        else                             cnt <= cnt + W'(1);
    end

    assign step_o = (cnt == W'(RATIO-1));
endmodule

// File: rtl/pix_sel_demux.sv
module pix_sel_demux
    import pix_seq_pkg::*;
#(
    parameter bit CLAMP = 1'b0,
    parameter int PASS  = ROWS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    input  logic             data_i,
    output logic [NCAP-1:0]  sel_o,
    output logic [PTR_W-1:0] ptr_o
);
    logic [PTR_W-1:0] ptr;
    assign ptr_o = ptr;

    generate
        if (!CLAMP) begin : g_std
            always_ff @(posedge clk) begin
                if (rst)        ptr <= '0;
                else if (adv_i) ptr <= next_ptr(ptr);
            end
            assign sel_o = route_sel(ptr, data_i);
        end else begin : g_clamp
            localparam int PW = $clog2(PASS);
            logic [PW-1:0] pass_cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    pass_cnt <= '0;
                    ptr      <= '0;
                end else if (adv_i) begin
                    if (pass_cnt == PW'(PASS-1)) begin
                        pass_cnt <= '0;
                        ptr      <= next_ptr(ptr);
                    end else begin
                        pass_cnt <= pass_cnt + PW'(1);
                    end
                end
            end
            assign sel_o = (ptr == PTR_W'(NCAP-1)) ? '0 : route_sel(ptr, data_i);
        end
    endgenerate
endmodule

// File: rtl/pix_row_shift.sv
module pix_row_shift
    import pix_seq_pkg::*;
#(
    parameter int DEPTH = STD_ROWS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   shift_i,
    input  cmd_t                   din_i,
    output logic [DEPTH*CMD_W-1:0] rows_o
);
    logic [CMD_W-1:0] stage [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst)          stage[g] <= '0;
                    else if (shift_i) stage[g] <= din_i;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst)          stage[g] <= '0;
                    else if (shift_i) stage[g] <= stage[g-1];
                end
            end
            assign rows_o[g*CMD_W +: CMD_W] = stage[g];
        end
    endgenerate
endmodule

// File: rtl/pix_row_seq.sv
module pix_row_seq
    import pix_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  line_step_i,
    input  logic                  data_i,
    input  logic                  prech_i,
    input  logic                  read_i,
    input  logic                  pwr_i,
    input  logic                  write_i,
    output logic                  step_o,
    output logic [ROWS*CMD_W-1:0] row_cmd_o
);
    ctl_t             raw, smp;
    cmd_t             std_cmd, clamp_cmd;
    logic [NCAP-1:0]  std_sel, clamp_sel;
    logic [PTR_W-1:0] std_ptr, clamp_phase;
    logic             step;

    always_comb begin
        raw.line  = line_step_i;
        raw.data  = data_i;
        raw.prech = prech_i;
        raw.read  = read_i;
        raw.pwr   = pwr_i;
        raw.write = write_i;
    end

    pix_sample u_sample (.clk(clk), .rst(rst), .d_i(raw), .q_o(smp));

    pix_step_div #(.RATIO(DIV)) u_div (.clk(clk), .rst(rst), .step_o(step));

    pix_sel_demux #(.CLAMP(1'b0), .PASS(ROWS)) u_std_sel (
        .clk(clk), .rst(rst), .adv_i(smp.line), .data_i(smp.data),
        .sel_o(std_sel), .ptr_o(std_ptr)
    );

    pix_sel_demux #(.CLAMP(1'b1), .PASS(ROWS)) u_clamp_sel (
        .clk(clk), .rst(rst), .adv_i(step), .data_i(smp.data),
        .sel_o(clamp_sel), .ptr_o(clamp_phase)
    );

    always_comb begin
        std_cmd.sel     = std_sel;
        std_cmd.write   = smp.write;
        std_cmd.pwr     = smp.pwr;
        std_cmd.read    = smp.read;
        std_cmd.prech   = smp.prech;
        clamp_cmd.sel   = clamp_sel;
        clamp_cmd.write = smp.write;
        clamp_cmd.pwr   = smp.pwr;
        clamp_cmd.read  = smp.read;
        clamp_cmd.prech = smp.prech;
    end

    pix_row_shift #(.DEPTH(STD_ROWS)) u_std_rows (
        .clk(clk), .rst(rst), .shift_i(step), .din_i(std_cmd),
        .rows_o(row_cmd_o[STD_ROWS*CMD_W-1:0])
    );

    pix_row_shift #(.DEPTH(CLAMP_ROWS)) u_clamp_rows (
        .clk(clk), .rst(rst), .shift_i(step), .din_i(clamp_cmd),
        .rows_o(row_cmd_o[ROWS*CMD_W-1:STD_ROWS*CMD_W])
    );

    assign step_o = step;
endmodule

// File: rtl/pix_row_seq_chk.sv
module pix_row_seq_chk
    import pix_seq_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  step_o,
    input logic [ROWS*CMD_W-1:0] row_cmd_o,
    input logic [PTR_W-1:0]      std_ptr,
    input logic [PTR_W-1:0]      clamp_phase
);
    cmd_t row0, row1, rowc;
    assign row0 = row_cmd_o[0 +: CMD_W];
    assign row1 = row_cmd_o[CMD_W +: CMD_W];
    assign rowc = row_cmd_o[STD_ROWS*CMD_W +: CMD_W];

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (row_cmd_o == '0 && !step_o));

    // R3
    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        step_o |=> !step_o);

    // R4
    a_r4_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row0.sel) && $onehot0(rowc.sel));

    // R5
    a_r5_ptr_walk: assert property (@(posedge clk) disable iff (rst)
        (std_ptr != $past(std_ptr)) |-> (std_ptr == next_ptr($past(std_ptr))));

    // R7
    a_r7_shift_down: assert property (@(posedge clk) disable iff (rst)
        step_o |=> (row1 == $past(row0)));

    // R8
    a_r8_hold_rows: assert property (@(posedge clk) disable iff (rst)
        !step_o |=> $stable(row_cmd_o));

    // R9
    a_r9_phase_on_step: assert property (@(posedge clk) disable iff (rst)
        !step_o |=> $stable(clamp_phase));

    // R10
    a_r10_blank_phase: assert property (@(posedge clk) disable iff (rst)
        (step_o && clamp_phase == PTR_W'(NCAP-1)) |=> (rowc.sel == '0));
endmodule

bind pix_row_seq pix_row_seq_chk u_chk (
    .clk(clk), .rst(rst), .step_o(step_o), .row_cmd_o(row_cmd_o),
    .std_ptr(std_ptr), .clamp_phase(clamp_phase)
);

// File: tb/pix_row_seq_tb.sv
module pix_row_seq_tb;
    localparam int NR = 48;
    localparam int NS = 40;
    localparam int DV = 6;
    localparam int NC = 4;
    localparam int W  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_i = 0, data_i = 0, prech_i = 0, read_i = 0, pwr_i = 0, write_i = 0;
    logic step;
    logic [NR*W-1:0] rows;

    always #10 clk = ~clk;

    pix_row_seq u_dut (
        .clk(clk), .rst(rst), .line_step_i(line_i), .data_i(data_i),
        .prech_i(prech_i), .read_i(read_i), .pwr_i(pwr_i), .write_i(write_i),
        .step_o(step), .row_cmd_o(rows)
    );

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // expectation state, advanced on the same edges as the design
    logic [5:0] m_s;          // {line,data,prech,read,pwr,write}
    int         m_cnt, m_ptr, m_cph, m_rc;
    logic       m_step_edge, m_blank;
    logic [W-1:0] m_rows [NR];

    function automatic logic [W-1:0] mk(input int p, input logic d, input logic blank,
                                        input logic [5:0] s);
        logic [3:0] sel;
        sel = (d && !blank) ? (4'b0001 << p) : 4'b0000;
        return {sel, s[0], s[1], s[2], s[3]};   // write, pwr, read, prech
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s <= '0; m_cnt <= 0; m_ptr <= 0; m_cph <= 0; m_rc <= 0;
            m_step_edge <= 0; m_blank <= 0;
            for (int r = 0; r < NR; r++) m_rows[r] <= '0;
        end else begin
            m_s <= {line_i, data_i, prech_i, read_i, pwr_i, write_i};
            m_cnt <= (m_cnt == DV-1) ? 0 : m_cnt + 1;
            if (m_s[5]) m_ptr <= (m_ptr + 1) % NC;
            m_step_edge <= (m_cnt == DV-1);
            m_blank <= (m_cnt == DV-1) && (m_cph == NC-1);
            if (m_cnt == DV-1) begin
                m_rows[0] <= mk(m_ptr, m_s[4], 1'b0, m_s);
                for (int r = 1; r < NS; r++) m_rows[r] <= m_rows[r-1];
                m_rows[NS] <= mk(m_cph, m_s[4], m_cph == NC-1, m_s);
                for (int r = NS+1; r < NR; r++) m_rows[r] <= m_rows[r-1];
                if (m_rc == NR-1) begin
                    m_rc <= 0;
                    m_cph <= (m_cph + 1) % NC;
                end else begin
                    m_rc <= m_rc + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [NR*W-1:0] prev_rows;
    bit prev_valid = 0;

    task automatic compare_all();
        logic [W-1:0] act;
        chk(step == (m_cnt == DV-1), "R3 step pulse", 64'(step), 64'(m_cnt == DV-1));
        for (int r = 0; r < NR; r++) begin
            act = rows[r*W +: W];
            if (r == 0)
                chk(act == m_rows[r], "R2 R5 R6 row0 word", 64'(act), 64'(m_rows[r]));
            else if (r == NS)
                chk(act == m_rows[r], "R9 clamp row word", 64'(act), 64'(m_rows[r]));
            else
                chk(act == m_rows[r], $sformatf("R7 row %0d", r), 64'(act), 64'(m_rows[r]));
            chk($onehot0(act[7:4]), $sformatf("R4 sel one-hot row %0d", r),
                64'(act[7:4]), 64'(m_rows[r][7:4]));
        end
        if (!rst && prev_valid && !m_step_edge)
            chk(rows == prev_rows, "R8 hold between steps", 64'(rows[63:0]), 64'(prev_rows[63:0]));
        if (!rst && m_blank)
            chk(rows[NS*W+4 +: 4] == 4'b0, "R10 blank clamp phase",
                64'(rows[NS*W+4 +: 4]), 64'd0);
        prev_rows  = rows;
        prev_valid = !rst;
    endtask

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (2) @(negedge clk);
        chk(rows == '0 && !step, "R1 reset state", 64'(rows[63:0]), 64'd0);
        compare_all();
        rst = 1'b0;
        prev_valid = 0;
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            compare_all();
            if (rst && n > 1500)
                chk(rows == '0 && !step, "R1 reset mid-run", 64'(rows[63:0]), 64'd0);
            if (n == 1500) begin rst = 1'b1; prev_valid = 0; end
            if (n == 1503) begin rst = 1'b0; prev_valid = 0; end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            line_i  = (lfsr[3:0] == 4'd0);
            data_i  = lfsr[4] | lfsr[7];
            prech_i = lfsr[5];
            read_i  = lfsr[6];
            pwr_i   = lfsr[8];
            write_i = lfsr[9];
        end
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule